// File: doc/BRIEF.md
# Dispatch Group Slot Hazard Checker

This block follows how a five-slot dispatch group fills while a scheduler offers it one candidate instruction per cycle. Each candidate carries an execution-unit code and a handful of flags: it must start a group, it must own the group alone, it splits into two slot-consuming pieces, it writes the branch counter, or it branches through that counter. A separate input bit reports that a memory-overlap check has found a load that hits a store already in the group. The block answers at once, combinationally, with one of three verdicts: clear to issue, stall until the next group, or insert a no-op.

The scheduler commits a candidate by pulsing `issue`, and it burns one empty slot by pulsing `advance`. State (slots used and whether a counter write has happened in this group) changes only on a clock edge carrying one of these strobes. When the group fills, the count and the counter-write flag both return to zero. If `issue` and `advance` arrive together, the issue is applied first. If that issue has already closed the group, the advance is rejected and flagged on `adv_err`.

Top module: `dgrp_hazard_chk`

## Requirements
- R1: After synchronous reset, `slots_used` is 0, no counter write is remembered, and a plain fixed-point candidate gets the verdict CLEAR (code 0).
- R2: A candidate whose `first_only` or `single_occ` flag is set, and whose unit is not pseudo, gets STALL (code 1) whenever `slots_used` is not 0.
- R3: A cracked candidate gets STALL when more than two slots are used. Issuing a cracked candidate consumes two slots.
- R4: Units fixed-point (1), load/store (2), floating-point (3), vector-ALU (4) and vector-permute (5) get STALL when four slots are used. A branch (7) is not stalled by the slot count, so it alone may take the last slot.
- R5: A condition-register unit candidate (6) gets STALL when two or more slots are used.
- R6: Issuing a branch or a single-occupancy candidate closes the group, and `slots_used` reads 0 on the next cycle.
- R7: After a counter-write candidate issues, a branch-through-counter candidate in the same group gets NOOP (code 2). After the group ends, the same candidate gets CLEAR.
- R8: A candidate with `mem_overlap` set, and with no slot stall, gets NOOP.
- R9: `advance` adds one to `slots_used`. When the count reaches five, the group ends and the count reads 0.
- R10: A pseudo candidate (unit 0) always gets CLEAR, whatever its flags. Issuing it changes neither the slot count nor the counter-write memory.
- R11: When `issue` and `advance` are both high and the issued candidate closes the group, `adv_err` is 1 and the advance is ignored. Otherwise `adv_err` is 0 and the advance applies after the issue.
- R12: When a slot rule gives STALL, STALL wins over any NOOP cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cand_unit | input | 3 | Unit code: 0 pseudo, 1 fixed, 2 load/store, 3 float, 4 vector ALU, 5 vector permute, 6 condition register, 7 branch |
| cand_first_only | input | 1 | Candidate may only start a group |
| cand_single_occ | input | 1 | Candidate occupies a whole group |
| cand_cracked | input | 1 | Candidate takes two slots |
| cand_ctr_wr | input | 1 | Candidate writes the branch counter |
| cand_br_ctr | input | 1 | Candidate branches through the counter |
| cand_mem_overlap | input | 1 | Load overlaps a store already in the group |
| issue | input | 1 | Commit the current candidate |
| advance | input | 1 | Burn one empty slot |
| verdict | output | 2 | 0 clear, 1 stall, 2 no-op |
| slots_used | output | 3 | Slots used in the current group |
| adv_err | output | 1 | Advance rejected because the group closed in the same cycle |

## Verification
On every cycle the assertions check that the slot count stays below five, that a wrap by advance and a close by branch issue return the count to zero, that a pseudo issue leaves the state untouched, that a start-only candidate stalls in a partly filled group, and that `adv_err` only appears with both strobes high. Only the bench's scenarios can show the full verdict table across units and fill levels, the counter-write memory living for exactly one group, the priority of stall over no-op, and the ordering of issue before advance in the same cycle.

// File: rtl/dgrp_pkg.sv
package dgrp_pkg;

    typedef enum logic [2:0] {
        U_PSEUDO = 3'd0,
        U_FXU    = 3'd1,
        U_LSU    = 3'd2,
        U_FPU    = 3'd3,
        U_VALU   = 3'd4,
        U_VPERM  = 3'd5,
        U_CRU    = 3'd6,
        U_BRU    = 3'd7
    } unit_e;

    typedef enum logic [1:0] {
        V_CLEAR = 2'd0,
        V_STALL = 2'd1,
        V_NOOP  = 2'd2
    } verdict_e;

    typedef struct packed {
        unit_e unit;
        logic  first_only;
        logic  single_occ;
        logic  cracked;
        logic  ctr_wr;
        logic  br_ctr;
        logic  mem_overlap;
    } cand_t;

    // Units that may never take the last slot of a group
    function automatic logic is_plain_unit(unit_e u);
        return (u == U_FXU) || (u == U_LSU) || (u == U_FPU) ||
               (u == U_VALU) || (u == U_VPERM);
    endfunction

    // Issuing this candidate ends the group regardless of fill level
    function automatic logic closes_group(cand_t c);
        return (c.unit == U_BRU) || c.single_occ;
    endfunction

endpackage

// File: rtl/dgrp_rules.sv
module dgrp_rules
    import dgrp_pkg::*;
#(
    parameter int GROUP_SLOTS = 5,
    parameter int CR_SLOTS    = 2,
    localparam int CNT_W      = $clog2(GROUP_SLOTS + 1)
) (
    input  cand_t              cand,
    input  logic [CNT_W-1:0]   used,
    input  logic               ctr_armed,
    output verdict_e           verdict
);

    localparam logic [CNT_W-1:0] LAST_SLOT   = CNT_W'(GROUP_SLOTS - 1);
    localparam logic [CNT_W-1:0] CRACK_LIMIT = CNT_W'(GROUP_SLOTS - 3);
    localparam logic [CNT_W-1:0] CR_LIMIT    = CNT_W'(CR_SLOTS);

    logic start_stall, crack_stall, unit_stall, slot_stall;
    logic ctr_noop, mem_noop;

    always_comb begin
        start_stall = (cand.first_only || cand.single_occ) && (used != '0);
        crack_stall = cand.cracked && (used > CRACK_LIMIT);
        unit_stall  = 1'b0;
        if (is_plain_unit(cand.unit))
            unit_stall = (used == LAST_SLOT);
        else if (cand.unit == U_CRU)
            unit_stall = (used >= CR_LIMIT);
        slot_stall = start_stall || crack_stall || unit_stall;
        ctr_noop   = ctr_armed && cand.br_ctr;
        mem_noop   = cand.mem_overlap;
    end

    always_comb begin
        if (cand.unit == U_PSEUDO)
            verdict = V_CLEAR;
        else if (slot_stall)
            verdict = V_STALL;
        else if (ctr_noop || mem_noop)
            verdict = V_NOOP;
        else
            verdict = V_CLEAR;
    end

endmodule

// File: rtl/dgrp_state.sv
module dgrp_state
    import dgrp_pkg::*;
#(
    parameter int GROUP_SLOTS = 5,
    localparam int CNT_W      = $clog2(GROUP_SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  cand_t            cand,
    input  logic             issue,
    input  logic             advance,
    output logic [CNT_W-1:0] used,
    output logic             ctr_armed,
    output logic             adv_err
);

    localparam logic [CNT_W:0]   FULL      = (CNT_W+1)'(GROUP_SLOTS);
    localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(GROUP_SLOTS - 1);

    logic             real_issue;
    logic             closed_by_issue;
    logic [CNT_W:0]   issue_sum;
    logic [CNT_W:0]   adv_sum;
    logic [CNT_W-1:0] after_issue;
    logic             arm_after_issue;
    logic [CNT_W-1:0] used_nxt;
    logic             arm_nxt;

    // Stage 1: effect of the issue strobe
    always_comb begin
        real_issue      = issue && (cand.unit != U_PSEUDO);
        closed_by_issue = 1'b0;
        after_issue     = used;
        arm_after_issue = ctr_armed;
        issue_sum       = {1'b0, used} + (CNT_W+1)'(1) + (CNT_W+1)'(cand.cracked);
        if (real_issue) begin
            if (cand.ctr_wr)
                arm_after_issue = 1'b1;
            if (closes_group(cand) || (issue_sum >= FULL))
                closed_by_issue = 1'b1;
            else
                after_issue = issue_sum[CNT_W-1:0];
        end
    end

    // Stage 2: effect of the advance strobe, applied after the issue
    always_comb begin
        adv_err  = advance && closed_by_issue;
        adv_sum  = {1'b0, after_issue} + (CNT_W+1)'(1);
        used_nxt = after_issue;
        arm_nxt  = arm_after_issue;
        if (closed_by_issue) begin
            used_nxt = '0;
            arm_nxt  = 1'b0;
        end else if (advance) begin
            if (adv_sum >= FULL) begin
                used_nxt = '0;
                arm_nxt  = 1'b0;
            end else begin
                used_nxt = adv_sum[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            used      <= '0;
            ctr_armed <= 1'b0;
        end else if (issue || advance) begin
            used      <= used_nxt;
            ctr_armed <= arm_nxt;
        end
    end

    // R9
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        used <= LAST_SLOT);

    // R9
    adv_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (advance && !issue && used == LAST_SLOT) |=> (used == '0));

    // R10
    pseudo_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (issue && !advance && cand.unit == U_PSEUDO) |=> ($stable(used) && $stable(ctr_armed)));

    // R6
    branch_close_chk: assert property (@(posedge clk) disable iff (rst)
        (issue && cand.unit == U_BRU) |=> (used == '0 && !ctr_armed));

endmodule

// File: rtl/dgrp_hazard_chk.sv
module dgrp_hazard_chk
    import dgrp_pkg::*;
#(
    parameter int GROUP_SLOTS = 5,
    parameter int CR_SLOTS    = 2,
    localparam int CNT_W      = $clog2(GROUP_SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       cand_unit,
    input  logic             cand_first_only,
    input  logic             cand_single_occ,
    input  logic             cand_cracked,
    input  logic             cand_ctr_wr,
    input  logic             cand_br_ctr,
    input  logic             cand_mem_overlap,
    input  logic             issue,
    input  logic             advance,
    output logic [1:0]       verdict,
    output logic [CNT_W-1:0] slots_used,
    output logic             adv_err
);

    cand_t            cand;
    verdict_e         verdict_w;
    logic [CNT_W-1:0] used_w;
    logic             armed_w;

    always_comb begin
        cand.unit        = unit_e'(cand_unit);
        cand.first_only  = cand_first_only;
        cand.single_occ  = cand_single_occ;
        cand.cracked     = cand_cracked;
        cand.ctr_wr      = cand_ctr_wr;
        cand.br_ctr      = cand_br_ctr;
        cand.mem_overlap = cand_mem_overlap;
    end

    dgrp_rules #(
        .GROUP_SLOTS (GROUP_SLOTS),
        .CR_SLOTS    (CR_SLOTS)
    ) u_rules (
        .cand      (cand),
        .used      (used_w),
        .ctr_armed (armed_w),
        .verdict   (verdict_w)
    );

    dgrp_state #(
        .GROUP_SLOTS (GROUP_SLOTS)
    ) u_state (
        .clk       (clk),
        .rst       (rst),
        .cand      (cand),
        .issue     (issue),
        .advance   (advance),
        .used      (used_w),
        .ctr_armed (armed_w),
        .adv_err   (adv_err)
    );

    assign verdict    = verdict_w;
    assign slots_used = used_w;

    // R11
    adv_err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        adv_err |-> (issue && advance));

    // R2
    start_stall_chk: assert property (@(posedge clk) disable iff (rst)
        ((cand_first_only || cand_single_occ) && slots_used != '0 && cand_unit != 3'd0)
            |-> (verdict == 2'd1));

    // R10
    pseudo_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (cand_unit == 3'd0) |-> (verdict == 2'd0));

endmodule

// File: tb/dgrp_hazard_chk_tb.sv
module dgrp_hazard_chk_tb;

    localparam logic [4:0] F_NONE   = 5'b00000;
    localparam logic [4:0] F_FIRST  = 5'b10000;
    localparam logic [4:0] F_SINGLE = 5'b01000;
    localparam logic [4:0] F_CRACK  = 5'b00100;
    localparam logic [4:0] F_CTRWR  = 5'b00010;
    localparam logic [4:0] F_BRCTR  = 5'b00001;

    localparam logic [2:0] PSEUDO = 3'd0, FXU = 3'd1, LSU = 3'd2, FPU = 3'd3,
                           VALU = 3'd4, VPERM = 3'd5, CRU = 3'd6, BRU = 3'd7;
    localparam logic [1:0] CLR = 2'd0, STL = 2'd1, NOP = 2'd2;

    typedef struct {
        logic [1:0] res;
        logic [2:0] cnt;
        logic       err;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] cand_unit = '0;
    logic       cand_first_only = 1'b0, cand_single_occ = 1'b0, cand_cracked = 1'b0;
    logic       cand_ctr_wr = 1'b0, cand_br_ctr = 1'b0, cand_mem_overlap = 1'b0;
    logic       issue = 1'b0, advance = 1'b0;
    logic [1:0] verdict;
    logic [2:0] slots_used;
    logic       adv_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    dgrp_hazard_chk u_dut (
        .clk              (clk),
        .rst              (rst),
        .cand_unit        (cand_unit),
        .cand_first_only  (cand_first_only),
        .cand_single_occ  (cand_single_occ),
        .cand_cracked     (cand_cracked),
        .cand_ctr_wr      (cand_ctr_wr),
        .cand_br_ctr      (cand_br_ctr),
        .cand_mem_overlap (cand_mem_overlap),
        .issue            (issue),
        .advance          (advance),
        .verdict          (verdict),
        .slots_used       (slots_used),
        .adv_err          (adv_err)
    );

    // Driver: apply one candidate for one cycle and queue its expectation
    task automatic step(input logic [2:0] u, input logic [4:0] fl, input logic ov,
                        input logic iss, input logic adv,
                        input logic [1:0] er, input logic [2:0] ec, input logic ee,
                        input string req);
        exp_t e;
        @(negedge clk);
        cand_unit        = u;
        cand_first_only  = fl[4];
        cand_single_occ  = fl[3];
        cand_cracked     = fl[2];
        cand_ctr_wr      = fl[1];
        cand_br_ctr      = fl[0];
        cand_mem_overlap = ov;
        issue            = iss;
        advance          = adv;
        e.res = er; e.cnt = ec; e.err = ee; e.req = req;
        sb_q.push_back(e);
    endtask

    // Monitor: compare outputs well after the falling edge
    always @(negedge clk) begin
        #1;
        while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (verdict !== e.res || slots_used !== e.cnt || adv_err !== e.err) begin
                errors++;
                $display("FAIL %s: verdict=%0d slots=%0d err=%0d expected verdict=%0d slots=%0d err=%0d",
                         e.req, verdict, slots_used, adv_err, e.res, e.cnt, e.err);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        step(FXU,   F_NONE,   0, 0, 0, CLR, 3'd0, 0, "R1");
        step(FXU,   F_NONE,   0, 1, 0, CLR, 3'd0, 0, "R1");
        // R2 start-only and single in a partial group
        step(FXU,   F_FIRST,  0, 0, 0, STL, 3'd1, 0, "R2");
        step(FXU,   F_SINGLE, 0, 0, 0, STL, 3'd1, 0, "R2");
        // R5 condition-register slots
        step(CRU,   F_NONE,   0, 1, 0, CLR, 3'd1, 0, "R5");
        step(CRU,   F_NONE,   0, 0, 0, STL, 3'd2, 0, "R5");
        // R3 cracked takes two slots
        step(FXU,   F_CRACK,  0, 1, 0, CLR, 3'd2, 0, "R3");
        // R4 last slot only for branches
        step(FXU,   F_NONE,   0, 0, 0, STL, 3'd4, 0, "R4");
        step(LSU,   F_NONE,   0, 0, 0, STL, 3'd4, 0, "R4");
        step(FPU,   F_NONE,   0, 0, 0, STL, 3'd4, 0, "R4");
        step(VALU,  F_NONE,   0, 0, 0, STL, 3'd4, 0, "R4");
        step(VPERM, F_NONE,   0, 0, 0, STL, 3'd4, 0, "R4");
        step(BRU,   F_NONE,   0, 1, 0, CLR, 3'd4, 0, "R4");
        step(PSEUDO,F_NONE,   0, 0, 0, CLR, 3'd0, 0, "R6");
        // R9 advance counting and wrap
        step(PSEUDO,F_NONE,   0, 0, 1, CLR, 3'd0, 0, "R9");
        step(PSEUDO,F_NONE,   0, 0, 1, CLR, 3'd1, 0, "R9");
        step(PSEUDO,F_NONE,   0, 0, 1, CLR, 3'd2, 0, "R9");
        step(FXU,   F_CRACK,  0, 0, 0, STL, 3'd3, 0, "R3");
        step(PSEUDO,F_NONE,   0, 0, 1, CLR, 3'd3, 0, "R9");
        step(PSEUDO,F_NONE,   0, 0, 1, CLR, 3'd4, 0, "R9");
        step(FXU,   F_NONE,   0, 0, 0, CLR, 3'd0, 0, "R9");
        // R7 counter write then branch through counter
        step(FXU,   F_CTRWR,  0, 1, 0, CLR, 3'd0, 0, "R7");
        step(BRU,   F_BRCTR,  0, 0, 0, NOP, 3'd1, 0, "R7");
        step(BRU,   F_BRCTR | F_FIRST, 0, 0, 0, STL, 3'd1, 0, "R12");
        step(PSEUDO,F_NONE,   0, 0, 1, CLR, 3'd1, 0, "R9");
        step(PSEUDO,F_NONE,   0, 0, 1, CLR, 3'd2, 0, "R9");
        step(PSEUDO,F_NONE,   0, 0, 1, CLR, 3'd3, 0, "R9");
        step(PSEUDO,F_NONE,   0, 0, 1, CLR, 3'd4, 0, "R9");
        step(BRU,   F_BRCTR,  0, 0, 0, CLR, 3'd0, 0, "R7");
        // R8 overlap and R12 priority
        step(LSU,   F_NONE,   1, 0, 0, NOP, 3'd0, 0, "R8");
        step(FXU,   F_NONE,   0, 1, 0, CLR, 3'd0, 0, "R8");
        step(LSU,   F_SINGLE, 1, 0, 0, STL, 3'd1, 0, "R12");
        // R10 pseudo ignored
        step(PSEUDO,F_FIRST | F_CTRWR, 0, 1, 0, CLR, 3'd1, 0, "R10");
        step(BRU,   F_BRCTR,  0, 0, 0, CLR, 3'd1, 0, "R10");
        // R6 closing by branch and by single
        step(BRU,   F_NONE,   0, 1, 0, CLR, 3'd1, 0, "R6");
        step(FXU,   F_SINGLE, 0, 1, 0, CLR, 3'd0, 0, "R6");
        step(FXU,   F_FIRST,  0, 0, 0, CLR, 3'd0, 0, "R6");
        // R11 issue and advance together
        step(BRU,   F_NONE,   0, 1, 1, CLR, 3'd0, 1, "R11");
        step(FXU,   F_NONE,   0, 1, 1, CLR, 3'd0, 0, "R11");
        step(FXU,   F_NONE,   0, 0, 0, CLR, 3'd2, 0, "R11");
        step(PSEUDO,F_NONE,   0, 0, 0, CLR, 3'd2, 0, "R11");
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule